// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing slave logic of a 2048-byte serial memory. It oversamples the two-wire clock and data lines with the system clock, finds START and STOP conditions, and checks the first byte of each transfer for a fixed four-bit device code. It acknowledges the bytes addressed to it and moves data between the bus and a byte-wide synchronous array outside the block. The array has a one-cycle read latency. The data line is split into a sampled input and a pull-low enable, so the pad and its open-drain behaviour stay outside the block.

The block supports five transfers: a single-byte write, a page write of up to 16 bytes, a read at the current address, a read at a chosen address (set by a write header, then a repeated START), and a sequential read that runs for as long as the master keeps acknowledging. Incoming write bytes are collected in a 16-entry page buffer and reach the array only after a STOP. Two inputs block that final step: a write-protect level and a low-supply flag. While either is high, the bus transfer still completes normally, but the array does not change.

The 11-bit address is formed from two parts. The upper three bits are bits 3:1 of the device byte, and the lower eight bits are the word-address byte.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While reset is held and right after its release, sda_oe_o and mem_we_o are 0 and mem_addr_o is 0.
- R2: A device byte whose bits 7:4 are 1010 is acknowledged (the data line is pulled low in the ninth clock). Any other code gets no acknowledge, and the block ignores the bus until the next START.
- R3: A single-byte write stores its data at {device bits 3:1, word address}. The array write happens only after the STOP.
- R4: In a page write, the low 4 address bits advance after each data byte and wrap inside the 16-byte page, so a later byte overwrites an earlier one. Bytes outside that page are left alone.
- R5: While wp_i is high, every byte of a write is still acknowledged, but no array location changes.
- R6: While low_vcc_i is high, every byte of a write is still acknowledged, but no array location changes.
- R7: A write header with a word address, followed by a repeated START and a read header, returns the byte stored at that address.
- R8: A read header with no address phase returns the byte that follows the last byte read.
- R9: In a read, each master acknowledge (data line low in the ninth clock) makes the block send the next byte. The 11-bit address wraps from 2047 to 0.
- R10: A START that arrives before the STOP discards any write bytes already received, and the array keeps its contents.
- R11: After a master non-acknowledge, the block stops driving the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | High to pull the data line low |
| wp_i | input | 1 | High makes the whole array read-only |
| low_vcc_i | input | 1 | High while the supply is too low to write |
| mem_addr_o | output | 11 | Array address |
| mem_we_o | output | 1 | Array write strobe, one byte per cycle |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, valid one cycle after the address |

## Verification
Every bus edge goes through two synchroniser stages and an edge register before the state machine sees it. As a result, an acknowledge or a transmitted bit appears on sda_oe_o three clock cycles after the SCL edge that calls for it. The bench holds each bus phase for ten cycles and samples only at the end of a phase, so each bit is read seven cycles after it is due. A STOP is seen three cycles after the data line rises, and the sixteen-cycle commit sweep follows it. The bench waits forty cycles after each STOP before it reads back, so no array check can fall inside the sweep.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_COMMIT
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_WORD,
        PH_DATA
    } phase_e;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [SYNC-1:0] scl_sh;
        logic [SYNC-1:0] sda_sh;
        logic            scl_p;
        logic            sda_p;
    } smp_t;

    smp_t smp_d, smp_q;
    logic scl_s, sda_s;

    assign scl_s = smp_q.scl_sh[SYNC-1];
    assign sda_s = smp_q.sda_sh[SYNC-1];

    always_comb begin
        smp_d        = smp_q;
        smp_d.scl_sh = {smp_q.scl_sh[SYNC-2:0], scl_i};
        smp_d.sda_sh = {smp_q.sda_sh[SYNC-2:0], sda_i};
        smp_d.scl_p  = scl_s;
        smp_d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~smp_q.scl_p;
    assign scl_fall_o = ~scl_s & smp_q.scl_p;
    assign start_o    = scl_s & smp_q.scl_p & smp_q.sda_p & ~sda_s;
    assign stop_o     = scl_s & smp_q.scl_p & ~smp_q.sda_p & sda_s;
endmodule

// File: rtl/i2c_page_buf.sv
module i2c_page_buf #(
    parameter int DW    = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_valid_o,
    output logic             any_valid_o
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] data;
        logic [DEPTH-1:0]         valid;
    } pbuf_t;

    pbuf_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (clear_i) begin
            pb_d.valid = '0;
        end else if (wr_en_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx_i == IDX_W'(i)) begin
                    pb_d.data[i]  = wr_data_i;
                    pb_d.valid[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign rd_data_o   = pb_q.data[rd_idx_i];
    assign rd_valid_o  = pb_q.valid[rd_idx_i];
    assign any_valid_o = |pb_q.valid;

    // R10: a clear leaves nothing pending
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !any_valid_o);
    // R4: a stored byte is pending afterwards
    assert_write_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clear_i) |=> any_valid_o);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int         ADDR_W   = 11,
    parameter int         PAGE_W   = 4,
    parameter int         SYNC     = 2,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wp_i,
    input  logic              low_vcc_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);
    import i2c_ee_pkg::*;

    localparam int BLK_W = ADDR_W - 8;

    typedef struct packed {
        bus_state_e        st;
        phase_e            ph;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [BLK_W-1:0]  blk;
        logic [ADDR_W-1:0] addr;
        logic              mack;
        logic [PAGE_W-1:0] cidx;
    } regs_t;

    regs_t r_d, r_q;

    logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic buf_wr, buf_clr, buf_rd_valid, buf_any;
    logic [7:0] buf_rd_data;

    i2c_line_sampler #(.SYNC(SYNC)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    i2c_page_buf #(.DW(8), .IDX_W(PAGE_W)) u_pbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (buf_clr),
        .wr_en_i     (buf_wr),
        .wr_idx_i    (r_q.addr[PAGE_W-1:0]),
        .wr_data_i   (r_q.sh),
        .rd_idx_i    (r_q.cidx),
        .rd_data_o   (buf_rd_data),
        .rd_valid_o  (buf_rd_valid),
        .any_valid_o (buf_any)
    );

    always_comb begin
        r_d     = r_q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        if (stop_evt && r_q.st != ST_COMMIT) begin
            if (r_q.ph == PH_DATA && buf_any) begin
                r_d.st   = ST_COMMIT;
                r_d.cidx = '0;
            end else begin
                r_d.st = ST_IDLE;
                r_d.ph = PH_DEV;
            end
        end else if (start_evt && r_q.st != ST_COMMIT) begin
            r_d.st  = ST_RX;
            r_d.ph  = PH_DEV;
            r_d.cnt = '0;
            buf_clr = 1'b1;
        end else begin
            case (r_q.st)
                ST_RX: begin
                    if (scl_rise && r_q.cnt != 4'd8) begin
                        r_d.sh  = {r_q.sh[6:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_ACK;
                        case (r_q.ph)
                            PH_DEV: begin
                                if (r_q.sh[7:4] == DEV_CODE) begin
                                    r_d.blk = r_q.sh[BLK_W:1];
                                    if (!r_q.sh[0]) r_d.ph = PH_WORD;
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            PH_WORD: begin
                                r_d.addr = {r_q.blk, r_q.sh};
                                r_d.ph   = PH_DATA;
                            end
                            default: begin
                                buf_wr = 1'b1;
                                r_d.addr[PAGE_W-1:0] = r_q.addr[PAGE_W-1:0] + 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (r_q.ph == PH_DEV) begin
                            r_d.st  = ST_TX;
                            r_d.sh  = mem_rdata_i;
                            r_d.cnt = '0;
                        end else begin
                            r_d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.st   = ST_MACK;
                            r_d.addr = r_q.addr + 1'b1;
                            r_d.cnt  = '0;
                        end else begin
                            r_d.sh  = {r_q.sh[6:0], 1'b0};
                            r_d.cnt = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st  = ST_TX;
                            r_d.sh  = mem_rdata_i;
                            r_d.cnt = '0;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_COMMIT: begin
                    r_d.cidx = r_q.cidx + 1'b1;
                    if (r_q.cidx == '1) begin
                        r_d.st  = ST_IDLE;
                        r_d.ph  = PH_DEV;
                        buf_clr = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe_o    = (r_q.st == ST_ACK) || (r_q.st == ST_TX && !r_q.sh[7]);
    assign mem_addr_o  = (r_q.st == ST_COMMIT) ? {r_q.addr[ADDR_W-1:PAGE_W], r_q.cidx} : r_q.addr;
    assign mem_we_o    = (r_q.st == ST_COMMIT) && buf_rd_valid && !wp_i && !low_vcc_i;
    assign mem_wdata_o = buf_rd_data;

    // R3: the array sweep begins only right after a STOP
    assert_commit_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COMMIT && $past(r_q.st) != ST_COMMIT) |-> $past(stop_evt));
    // R9: each finished read byte advances the full address by one
    assert_read_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MACK && $past(r_q.st) == ST_TX) |-> r_q.addr == $past(r_q.addr) + 1'b1);
    // R4: storing a page byte never moves the page
    assert_page_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> r_q.addr[ADDR_W-1:PAGE_W] == $past(r_q.addr[ADDR_W-1:PAGE_W]));
endmodule

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic lowv = 1'b0;
    logic sda_oe, mem_we;
    logic [10:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic sda_line;
    logic [7:0] mem [2048];
    logic [7:0] model [2048];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .wp_i        (wp),
        .low_vcc_i   (lowv),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // stimulus table: {address, data}; expected read-back equals data
    localparam logic [18:0] VEC [6] = '{
        {11'h000, 8'hC3}, {11'h7FF, 8'h3C}, {11'h130, 8'h77},
        {11'h005, 8'h5A}, {11'h050, 8'h11}, {11'h2A9, 8'h96}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        repeat (40) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        ack = ~sda_line;
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl_m = 1'b1; qwait();
            b[i] = sda_line;
            scl_m = 1'b0;
        end
        sda_m = ~mack; qwait();
        scl_m = 1'b1; qwait();
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    task automatic byte_write(input logic [10:0] a, input logic [7:0] d, output logic acks);
        logic k0, k1, k2;
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0}, k0);
        send_byte(a[7:0], k1);
        send_byte(d, k2);
        bus_stop();
        acks = k0 & k1 & k2;
        if (!wp && !lowv) model[a] = d;
    endtask

    task automatic set_addr_read(input logic [10:0] a);
        logic k;
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0}, k);
        send_byte(a[7:0], k);
        bus_start();
        send_byte({4'hA, a[10:8], 1'b1}, k);
    endtask

    task automatic rand_read(input logic [10:0] a, output logic [7:0] d);
        set_addr_read(a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        logic ok;
        logic [7:0] rd;
        logic [10:0] a;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 sda_oe in reset", int'(sda_oe), 0);
        chk("R1 we in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 addr after reset", int'(mem_addr), 0);
        chk("R1 sda_oe after reset", int'(sda_oe), 0);

        // table walk: R2 R3 R7
        for (int v = 0; v < 6; v++) begin
            byte_write(VEC[v][18:8], VEC[v][7:0], ok);
            chk("R2 acks on byte write", int'(ok), 1);
            rand_read(VEC[v][18:8], rd);
            chk("R3 R7 random read back", int'(rd), int'(VEC[v][7:0]));
        end

        // R2: foreign device code is not acknowledged
        bus_start();
        send_byte(8'hB0, ok);
        chk("R2 foreign code nack", int'(ok), 0);
        bus_stop();
        chk("R2 line released", int'(sda_oe), 0);

        // R4: 18 bytes from offset 0xE of page 0x120 wrap inside the page
        bus_start();
        send_byte({4'hA, 3'h1, 1'b0}, ok);
        send_byte(8'h2E, ok);
        for (int k = 0; k < 18; k++) begin
            send_byte(8'h40 + 8'(k), ok);
            chk("R4 page byte ack", int'(ok), 1);
            model[11'h120 + 11'((14 + k) % 16)] = 8'h40 + 8'(k);
        end
        bus_stop();
        set_addr_read(11'h120);
        for (int k = 0; k < 16; k++) begin
            recv_byte(k != 15, rd);
            chk("R4 page contents", int'(rd), int'(model[11'h120 + 11'(k)]));
        end
        bus_stop();
        rand_read(11'h130, rd);
        chk("R4 next page untouched", int'(rd), 8'h77);

        // R5: write protect
        wp = 1'b1;
        byte_write(11'h005, 8'hEE, ok);
        chk("R5 acks while protected", int'(ok), 1);
        wp = 1'b0;
        rand_read(11'h005, rd);
        chk("R5 protected byte unchanged", int'(rd), int'(model[11'h005]));

        // R6: low supply
        lowv = 1'b1;
        byte_write(11'h2A9, 8'h01, ok);
        chk("R6 acks while low supply", int'(ok), 1);
        lowv = 1'b0;
        rand_read(11'h2A9, rd);
        chk("R6 low-supply byte unchanged", int'(rd), 8'h96);

        // R8: current address read follows last byte read
        rand_read(11'h120, rd);
        bus_start();
        send_byte({4'hA, 3'h0, 1'b1}, ok);
        recv_byte(1'b0, rd);
        bus_stop();
        chk("R8 current address read", int'(rd), int'(model[11'h121]));

        // R9: sequential read wraps 2047 -> 0
        set_addr_read(11'h7FF);
        recv_byte(1'b1, rd);
        chk("R9 byte at 2047", int'(rd), 8'h3C);
        recv_byte(1'b0, rd);
        // R11: line released after master nack
        chk("R11 released after nack", int'(sda_oe), 0);
        bus_stop();
        chk("R9 wrapped to 0", int'(rd), 8'hC3);

        // R10: repeated START aborts buffered write
        a = 11'h050;
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0}, ok);
        send_byte(a[7:0], ok);
        send_byte(8'h99, ok);
        bus_start();
        bus_stop();
        rand_read(a, rd);
        chk("R10 aborted write discarded", int'(rd), 8'h11);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule